// File: doc/BRIEF.md
# Timestamp Trust and Tariff Window Tracker

This block keeps the metering time base together with a statement of how far that time can be trusted. A seconds counter advances on a one-per-second strobe. Next to it, a four-state machine classifies the time as valid, suspect or invalid. The machine reacts to supply switchover strobes, to loss of the backup supply, to a host time-set command, and to an internal holdover timer that bounds how long time may run on backup before it is presumed to have drifted.

From the seconds counter the block derives the second of the day. It compares this against a programmable table of eight ascending boundaries and reports the current tariff window index. Every quality change, every time-set and every tick-driven window change produces a marker for an event logger. Markers that arise together are serialised in a fixed priority order. The logger can hold the marker output with a stall input.

Top module: `rtc_trust_tou`

The quality machine has four states:
- `S_INVALID` (reset state) reports invalid.
- `S_VALID` reports valid.
- `S_SUSP_TIMED` reports suspect and returns to valid by itself.
- `S_SUSP_HELD` reports suspect and leaves only through a time-set or a backup loss.

The machine has these transitions:
- Backup loss: any state goes to `S_INVALID`.
- Time-set with backup present: any state goes to `S_VALID`.
- Switchover: `S_VALID` goes to `S_SUSP_TIMED`. A switchover in `S_SUSP_TIMED` reloads its window.
- Window expiry after SUSP_SEC ticks: `S_SUSP_TIMED` goes to `S_VALID`.
- Drift: `S_VALID` or `S_SUSP_TIMED` goes to `S_SUSP_HELD`.

## Requirements
- R1: The `quality` code is 2'b00 for valid, 2'b01 for suspect and 2'b10 for invalid; 2'b11 never appears. After reset, `quality` is invalid, `now_time` is 0, `win_idx` is 0 and `mk_valid` is 0.
- R2: A `sw_to_bkp` or `sw_to_main` strobe in the valid state makes `quality` suspect from the next cycle. Quality returns to valid on the SUSP_SEC-th (default 3) following `sec_tick`. Both transitions emit a quality marker.
- R3: A `set_req` loads `set_time` into `now_time` and emits a set marker (`mk_kind` 2'b01, `mk_time` = `set_time`). In that marker, `mk_aux[0]` is 1 exactly when `set_time` is below the previous time.
- R4: Without `set_req`, `now_time` rises by exactly one on a `sec_tick` cycle and holds otherwise.
- R5: A low `bkp_present` makes `quality` invalid from the next cycle and emits a quality marker. The return of `bkp_present` alone leaves `quality` invalid.
- R6: After a `set_req`, `quality` is valid when `bkp_present` is high and invalid when it is low.
- R7: The holdover timer counts `sec_tick` strobes after `sw_to_bkp` until `sw_to_main`, and it restarts on `set_req`. On the tick that reaches `hold_limit`, quality becomes suspect and stays suspect through later ticks until a time-set or a backup loss.
- R8: `win_idx` is the count of table entries at or below the second of day (`now_time` mod 86400), minus one. When no entry qualifies, it is 7, so the last window of the day runs on past midnight. After reset, entry i holds i*10800. A `tbl_we` writes `tbl_data` to entry `tbl_addr`.
- R9: A tick-driven change of `win_idx` emits a window marker (`mk_kind` 2'b10, `mk_aux` = new index, `mk_qual` = current quality, `mk_time` = new time). A change caused by `set_req` emits no window marker.
- R10: Marker kinds are ranked quality (2'b00, `mk_aux[1:0]` = previous quality, `mk_qual` = new quality) first, then set, then window. Markers raised together leave in that order. While `mk_valid` and `mk_stall` are both high, the marker outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second advance strobe |
| bkp_present | input | 1 | Backup supply present level |
| sw_to_bkp | input | 1 | Main-to-backup switchover strobe |
| sw_to_main | input | 1 | Backup-to-main switchover strobe |
| set_req | input | 1 | Host time-set strobe |
| set_time | input | 32 | New time value for a time-set |
| hold_limit | input | 16 | Holdover tick count that flags drift (0 disables) |
| tbl_we | input | 1 | Boundary table write strobe |
| tbl_addr | input | 3 | Boundary table entry to write |
| tbl_data | input | 17 | Second-of-day boundary value to write |
| mk_stall | input | 1 | Logger back-pressure; holds the current marker |
| now_time | output | 32 | Current seconds count |
| quality | output | 2 | Time quality code |
| win_idx | output | 3 | Current tariff window index |
| mk_valid | output | 1 | Marker present |
| mk_kind | output | 2 | Marker kind |
| mk_time | output | 32 | Time attached to the marker |
| mk_qual | output | 2 | Quality attached to the marker |
| mk_aux | output | 3 | Previous quality, backward flag or window index |

## Verification
A time-set and a quality transition can land in the same cycle. This happens when the host sets time while quality is held suspect by drift, or while it is invalid. The bench provokes the first case with `mk_stall` held high, so both markers sit pending. It checks that the quality marker is presented first and stays stable under the stall. After the stall is released, the scoreboard expects the quality marker and then the set marker, each with its backward flag and quality fields as predicted.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
    parameter int TIME_W  = 32;
    parameter int SOD_W   = 17;
    parameter int DAY_SEC = 86400;
    parameter int NUM_WIN = 8;
    localparam int WIN_W  = $clog2(NUM_WIN);

    typedef enum logic [1:0] {
        Q_VALID   = 2'b00,
        Q_SUSPECT = 2'b01,
        Q_INVALID = 2'b10
    } quality_e;

    typedef enum logic [1:0] {
        MK_QUAL = 2'b00,
        MK_SET  = 2'b01,
        MK_WIN  = 2'b10
    } mk_kind_e;

    typedef struct packed {
        mk_kind_e            kind;
        logic [TIME_W-1:0]   stamp;
        quality_e            qual;
        logic [WIN_W-1:0]    aux;
    } marker_t;
endpackage

// File: rtl/rtq_holdover.sv
module rtq_holdover #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              sw_to_bkp,
    input  logic              sw_to_main,
    input  logic              restart,
    input  logic [HOLD_W-1:0] limit,
    output logic              drift_hit
);
    logic              on_bkp;
    logic [HOLD_W-1:0] cnt;

    // strobe on the tick that brings the count up to the limit
    always_comb begin
        drift_hit = on_bkp && sec_tick && !restart && !sw_to_bkp && !sw_to_main
                    && (limit != '0) && (cnt == limit - HOLD_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_bkp <= 1'b0;
            cnt    <= '0;
        end else if (sw_to_bkp) begin
            on_bkp <= 1'b1;
            cnt    <= '0;
        end else if (sw_to_main) begin
            on_bkp <= 1'b0;
            cnt    <= '0;
        end else if (restart) begin
            cnt    <= '0;
        end else if (on_bkp && sec_tick && cnt != limit) begin
            cnt    <= cnt + HOLD_W'(1);
        end
    end
endmodule

// File: rtl/rtq_quality_fsm.sv
module rtq_quality_fsm
    import rtq_pkg::*;
#(
    parameter int SUSP_SEC = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sec_tick,
    input  logic     bkp_present,
    input  logic     switch_ev,
    input  logic     set_req,
    input  logic     drift_hit,
    output quality_e q_cur,
    output quality_e q_nxt,
    output logic     q_change
);
    localparam int WC_W = $clog2(SUSP_SEC + 1);

    typedef enum logic [1:0] {
        S_INVALID,
        S_VALID,
        S_SUSP_TIMED,
        S_SUSP_HELD
    } state_e;

    state_e          st, st_n;
    logic [WC_W-1:0] wcnt, wcnt_n;

    function automatic quality_e q_of(input state_e s);
        case (s)
            S_VALID:                   q_of = Q_VALID;
            S_SUSP_TIMED, S_SUSP_HELD: q_of = Q_SUSPECT;
            default:                   q_of = Q_INVALID;
        endcase
    endfunction

    // next state
    always_comb begin
        st_n   = st;
        wcnt_n = wcnt;
        if (!bkp_present) begin
            st_n = S_INVALID;
        end else if (set_req) begin
            st_n = S_VALID;
        end else begin
            unique case (st)
                S_INVALID: st_n = st;
                S_VALID: begin
                    if (drift_hit) begin
                        st_n = S_SUSP_HELD;
                    end else if (switch_ev) begin
                        st_n   = S_SUSP_TIMED;
                        wcnt_n = WC_W'(SUSP_SEC);
                    end
                end
                S_SUSP_TIMED: begin
                    if (drift_hit) begin
                        st_n = S_SUSP_HELD;
                    end else if (switch_ev) begin
                        wcnt_n = WC_W'(SUSP_SEC);
                    end else if (sec_tick) begin
                        if (wcnt == WC_W'(1)) st_n = S_VALID;
                        wcnt_n = wcnt - WC_W'(1);
                    end
                end
                S_SUSP_HELD: st_n = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_INVALID;
            wcnt <= '0;
        end else begin
            st   <= st_n;
            wcnt <= wcnt_n;
        end
    end

    // outputs
    always_comb begin
        q_cur    = q_of(st);
        q_nxt    = q_of(st_n);
        q_change = (q_cur != q_nxt);
    end
endmodule

// File: rtl/rtq_tou_table.sv
module rtq_tou_table
    import rtq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIN_W-1:0]  addr,
    input  logic [SOD_W-1:0]  data,
    input  logic [TIME_W-1:0] now,
    output logic [WIN_W-1:0]  idx
);
    localparam int STEP = DAY_SEC / NUM_WIN;

    logic [SOD_W-1:0]  bnd [NUM_WIN];
    logic [NUM_WIN-1:0] le;
    logic [TIME_W-1:0] sod;
    logic [WIN_W:0]    hits;

    assign sod = now % TIME_W'(DAY_SEC);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bnd[i] <= SOD_W'(i * STEP);
            else if (we && addr == WIN_W'(i))
                bnd[i] <= data;
        end
        assign le[i] = ({{(TIME_W-SOD_W){1'b0}}, bnd[i]} <= sod);
    end

    always_comb begin
        hits = '0;
        for (int k = 0; k < NUM_WIN; k++)
            hits = hits + {{WIN_W{1'b0}}, le[k]};
        if (hits == '0)
            idx = WIN_W'(NUM_WIN - 1);
        else
            idx = WIN_W'(hits - (WIN_W+1)'(1));
    end
endmodule

// File: rtl/rtq_marker_arb.sv
module rtq_marker_arb
    import rtq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    ev,
    input  marker_t [2:0] pl,
    input  logic          stall,
    output logic          out_v,
    output marker_t       out_mk
);
    logic [2:0]    pend;
    marker_t [2:0] slot;
    logic [2:0]    pick;
    logic          take;
    marker_t       sel;

    assign take = !out_v || !stall;

    // lower index wins
    always_comb begin
        pick = '0;
        if (take) begin
            if (pend[0])      pick[0] = 1'b1;
            else if (pend[1]) pick[1] = 1'b1;
            else if (pend[2]) pick[2] = 1'b1;
        end
        sel = slot[0];
        for (int k = 2; k >= 0; k--)
            if (pick[k]) sel = slot[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            slot <= '0;
        end else begin
            for (int k = 0; k < 3; k++) begin
                if (ev[k]) begin
                    pend[k] <= 1'b1;
                    slot[k] <= pl[k];
                end else if (pick[k]) begin
                    pend[k] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v  <= 1'b0;
            out_mk <= '0;
        end else if (take) begin
            out_v <= |pick;
            if (|pick) out_mk <= sel;
        end
    end
endmodule

// File: rtl/rtc_trust_tou.sv
module rtc_trust_tou
    import rtq_pkg::*;
#(
    parameter int SUSP_SEC = 3,
    parameter int HOLD_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_tick,
    input  logic                 bkp_present,
    input  logic                 sw_to_bkp,
    input  logic                 sw_to_main,
    input  logic                 set_req,
    input  logic [TIME_W-1:0]    set_time,
    input  logic [HOLD_W-1:0]    hold_limit,
    input  logic                 tbl_we,
    input  logic [WIN_W-1:0]     tbl_addr,
    input  logic [SOD_W-1:0]     tbl_data,
    input  logic                 mk_stall,
    output logic [TIME_W-1:0]    now_time,
    output logic [1:0]           quality,
    output logic [WIN_W-1:0]     win_idx,
    output logic                 mk_valid,
    output logic [1:0]           mk_kind,
    output logic [TIME_W-1:0]    mk_time,
    output logic [1:0]           mk_qual,
    output logic [WIN_W-1:0]     mk_aux
);
    logic [TIME_W-1:0] now_r, time_nxt;
    logic              drift_hit;
    quality_e          q_cur, q_nxt;
    logic              q_change;
    logic [WIN_W-1:0]  idx, idx_prev;
    logic              tick_d;
    logic [2:0]        ev;
    marker_t [2:0]     pl;
    marker_t           mk;

    // seconds counter: only a set may move it backward
    always_comb begin
        time_nxt = now_r;
        if (set_req)       time_nxt = set_time;
        else if (sec_tick) time_nxt = now_r + TIME_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_r    <= '0;
            idx_prev <= '0;
            tick_d   <= 1'b0;
        end else begin
            now_r    <= time_nxt;
            idx_prev <= idx;
            tick_d   <= sec_tick && !set_req;
        end
    end

    rtq_holdover #(.HOLD_W(HOLD_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .sw_to_bkp  (sw_to_bkp),
        .sw_to_main (sw_to_main),
        .restart    (set_req),
        .limit      (hold_limit),
        .drift_hit  (drift_hit)
    );

    rtq_quality_fsm #(.SUSP_SEC(SUSP_SEC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .bkp_present (bkp_present),
        .switch_ev   (sw_to_bkp | sw_to_main),
        .set_req     (set_req),
        .drift_hit   (drift_hit),
        .q_cur       (q_cur),
        .q_nxt       (q_nxt),
        .q_change    (q_change)
    );

    rtq_tou_table u_tou (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .addr  (tbl_addr),
        .data  (tbl_data),
        .now   (now_r),
        .idx   (idx)
    );

    // marker sources, index order = priority
    always_comb begin
        ev[0] = q_change;
        ev[1] = set_req;
        ev[2] = tick_d && (idx != idx_prev);

        pl[0].kind  = MK_QUAL;
        pl[0].stamp = time_nxt;
        pl[0].qual  = q_nxt;
        pl[0].aux   = WIN_W'(q_cur);

        pl[1].kind  = MK_SET;
        pl[1].stamp = set_time;
        pl[1].qual  = q_nxt;
        pl[1].aux   = {{(WIN_W-1){1'b0}}, (set_time < now_r)};

        pl[2].kind  = MK_WIN;
        pl[2].stamp = now_r;
        pl[2].qual  = q_cur;
        pl[2].aux   = idx;
    end

    rtq_marker_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .pl     (pl),
        .stall  (mk_stall),
        .out_v  (mk_valid),
        .out_mk (mk)
    );

    assign now_time = now_r;
    assign quality  = q_cur;
    assign win_idx  = idx;
    assign mk_kind  = mk.kind;
    assign mk_time  = mk.stamp;
    assign mk_qual  = mk.qual;
    assign mk_aux   = mk.aux;
endmodule

// File: rtl/rtq_checker.sv
module rtq_checker
    import rtq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bkp_present,
    input logic              sw_to_bkp,
    input logic              sw_to_main,
    input logic              set_req,
    input logic              mk_stall,
    input logic [TIME_W-1:0] now_time,
    input logic [1:0]        quality,
    input logic              mk_valid,
    input logic [1:0]        mk_kind,
    input logic [TIME_W-1:0] mk_time
);
    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        quality != 2'b11);

    p_switch_suspect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (quality == 2'b00 && (sw_to_bkp || sw_to_main) && bkp_present && !set_req)
        |=> quality == 2'b01);

    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && sec_tick) |=> now_time == $past(now_time) + TIME_W'(1));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !sec_tick) |=> $stable(now_time));

    p_loss_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bkp_present |=> quality == 2'b10);

    p_set_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && bkp_present) |=> quality == 2'b00);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mk_valid && mk_stall) |=> (mk_valid && $stable(mk_kind) && $stable(mk_time)));
endmodule

bind rtc_trust_tou rtq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .bkp_present (bkp_present),
    .sw_to_bkp   (sw_to_bkp),
    .sw_to_main  (sw_to_main),
    .set_req     (set_req),
    .mk_stall    (mk_stall),
    .now_time    (now_time),
    .quality     (quality),
    .mk_valid    (mk_valid),
    .mk_kind     (mk_kind),
    .mk_time     (mk_time)
);

// File: tb/rtc_trust_tou_test.sv
module rtc_trust_tou_test;
    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] t;
        logic [1:0]  q;
        logic [2:0]  aux;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0, bkp_present = 1'b1, sw_to_bkp = 1'b0, sw_to_main = 1'b0;
    logic        set_req = 1'b0;
    logic [31:0] set_time = '0;
    logic [15:0] hold_limit = 16'd5;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [16:0] tbl_data = '0;
    logic        mk_stall = 1'b0;
    logic [31:0] now_time, mk_time;
    logic [1:0]  quality, mk_kind, mk_qual;
    logic [2:0]  win_idx, mk_aux;
    logic        mk_valid;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    rtc_trust_tou uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bkp_present(bkp_present),
        .sw_to_bkp(sw_to_bkp), .sw_to_main(sw_to_main), .set_req(set_req),
        .set_time(set_time), .hold_limit(hold_limit), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .mk_stall(mk_stall),
        .now_time(now_time), .quality(quality), .win_idx(win_idx),
        .mk_valid(mk_valid), .mk_kind(mk_kind), .mk_time(mk_time),
        .mk_qual(mk_qual), .mk_aux(mk_aux)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [1:0] k, input logic [31:0] t, input logic [1:0] q, input logic [2:0] a);
        sb.push_back('{kind: k, t: t, q: q, aux: a});
    endtask

    task automatic tick();
        sec_tick = 1'b1; cyc(); sec_tick = 1'b0; cyc();
    endtask

    task automatic do_set(input logic [31:0] v);
        set_time = v; set_req = 1'b1; cyc(); set_req = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 40 && sb.size() != 0; i++) cyc();
        cyc(); cyc();
        chk(sb.size() == 0, req, sb.size(), 0);
    endtask

    // monitor: compare each accepted marker with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && mk_valid && !mk_stall) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 unexpected marker kind=%0d time=%0d expected=none", mk_kind, mk_time);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({mk_kind, mk_time, mk_qual, mk_aux} == e, "R10 marker",
                    {mk_kind, mk_qual, mk_aux, mk_time[24:0]}, {e.kind, e.q, e.aux, e.t[24:0]});
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk(quality == 2'd2, "R1 quality", quality, 2);
        chk(now_time == 0, "R1 time", now_time, 0);
        chk(win_idx == 0, "R1 window", win_idx, 0);
        chk(mk_valid == 1'b0, "R1 marker", mk_valid, 0);

        // R6 R3 first set
        push(2'd0, 1000, 2'd0, 3'd2);
        push(2'd1, 1000, 2'd0, 3'd0);
        do_set(1000);
        chk(quality == 2'd0, "R6 valid after set", quality, 0);
        chk(now_time == 1000, "R3 loaded", now_time, 1000);
        drain("R3 markers");

        // R4 counting
        for (int i = 0; i < 5; i++) tick();
        chk(now_time == 1005, "R4 advance", now_time, 1005);

        // R9 crossing by ticks
        push(2'd1, 10798, 2'd0, 3'd0);
        do_set(10798);
        push(2'd2, 10800, 2'd0, 3'd1);
        tick(); tick();
        drain("R9 crossing");
        chk(win_idx == 1, "R8 window one", win_idx, 1);

        // R2 timed suspect, R7 drift
        push(2'd0, 10800, 2'd1, 3'd0);
        sw_to_bkp = 1'b1; cyc(); sw_to_bkp = 1'b0;
        chk(quality == 2'd1, "R2 suspect", quality, 1);
        tick(); tick();
        chk(quality == 2'd1, "R2 still suspect", quality, 1);
        push(2'd0, 10803, 2'd0, 3'd1);
        tick();
        chk(quality == 2'd0, "R2 back to valid", quality, 0);
        tick();
        push(2'd0, 10805, 2'd1, 3'd0);
        tick();
        chk(quality == 2'd1, "R7 drift suspect", quality, 1);
        tick(); tick(); tick();
        chk(quality == 2'd1, "R7 held suspect", quality, 1);
        drain("R7 markers");

        // R10 simultaneous quality and set under stall; R3 backward
        mk_stall = 1'b1;
        push(2'd0, 500, 2'd0, 3'd1);
        push(2'd1, 500, 2'd0, 3'd1);
        do_set(500);
        cyc(); cyc(); cyc();
        chk(mk_valid == 1'b1, "R10 held valid", mk_valid, 1);
        chk(mk_kind == 2'd0, "R10 quality first", mk_kind, 0);
        mk_stall = 1'b0;
        drain("R10 order");
        chk(win_idx == 0, "R9 set gives no crossing", win_idx, 0);

        // R2 via backup-to-main
        push(2'd0, 500, 2'd1, 3'd0);
        sw_to_main = 1'b1; cyc(); sw_to_main = 1'b0;
        tick(); tick();
        push(2'd0, 503, 2'd0, 3'd1);
        tick();
        drain("R2 main switch");

        // R5 backup loss and return
        push(2'd0, 503, 2'd2, 3'd0);
        bkp_present = 1'b0; cyc();
        chk(quality == 2'd2, "R5 invalid", quality, 2);
        tick();
        chk(now_time == 504, "R4 runs while invalid", now_time, 504);
        bkp_present = 1'b1; cyc(); cyc(); cyc();
        chk(quality == 2'd2, "R5 stays invalid", quality, 2);
        drain("R5 markers");

        // R6 set restores; R8 last window before midnight
        push(2'd0, 86399, 2'd0, 3'd2);
        push(2'd1, 86399, 2'd0, 3'd0);
        do_set(86399);
        chk(win_idx == 7, "R8 last window", win_idx, 7);
        push(2'd2, 86400, 2'd0, 3'd0);
        tick();
        drain("R9 midnight");
        chk(win_idx == 0, "R8 wrap", win_idx, 0);

        // R8 programmed boundary
        tbl_addr = 3'd1; tbl_data = 17'd2; tbl_we = 1'b1; cyc(); tbl_we = 1'b0;
        chk(win_idx == 0, "R8 write no move", win_idx, 0);
        push(2'd2, 86402, 2'd0, 3'd1);
        tick(); tick();
        drain("R8 programmed");
        chk(win_idx == 1, "R8 new boundary", win_idx, 1);

        // R6 set without backup stays invalid
        push(2'd0, 86402, 2'd2, 3'd0);
        bkp_present = 1'b0; cyc();
        push(2'd1, 90000, 2'd2, 3'd0);
        do_set(90000);
        chk(quality == 2'd2, "R6 no backup", quality, 2);
        chk(now_time == 90000, "R3 set while invalid", now_time, 90000);
        drain("R6 markers");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule